// File: doc/BRIEF.md
# PoE Port Detection and Classification Sequencer

This block is the control state machine for one port of a power-sourcing Ethernet switch. It takes the port from idle through signature detection and classification to power-on. Its inputs are already digitised: a signature resistance code, a classification current code, a power-good comparator bit, a shutdown request and three command strobes. Its outputs are the external FET gate enable, the detected class, a detect-valid flag and single-cycle event pulses for an interrupt block. A free-running millisecond tick times every phase.

The operating mode is a two-bit input. In manual mode (`2'b00`), each step waits for its own command strobe. In semi-automatic mode (`2'b01`), detection and classification run by themselves, and power-on still waits for a command. In automatic mode (`2'b1x`), the whole flow runs unattended, with a short settle delay before the gate turns on. The resistance code is in units of 0.25 kΩ and the current code in units of 0.5 mA.

The states are `ST_IDLE`, `ST_BACKOFF`, `ST_DETECT`, `ST_DET_HOLD`, `ST_CLASS`, `ST_WAIT_ON` and `ST_POWERED`. The transitions are:
- IDLE→DETECT: on entry in automatic or semi-automatic mode, or on `cmd_detect` in manual mode.
- DETECT→CLASS: a valid signature in automatic or semi-automatic mode.
- DETECT→DET_HOLD: a valid signature in manual mode.
- DETECT→BACKOFF or DETECT→IDLE: an invalid signature (backoff in the automatic modes, idle in manual).
- DET_HOLD→CLASS: on `cmd_classify`.
- CLASS→WAIT_ON: a class between 0 and 4.
- CLASS→BACKOFF or CLASS→IDLE: overcurrent.
- BACKOFF→IDLE: when the backoff time expires.
- WAIT_ON→POWERED: when the settle timer expires in automatic mode, or on `cmd_power` in the other modes.
- Any state→IDLE: on `shdn`.

Top module: `pse_port_seq`

## Requirements
- R1: While reset is asserted and right after it, `gate_en`, `det_valid`, `pwr_good`, `port_class` and all event pulses are 0.
- R2: Detection lasts DET_MS ticks (default 200). The signature is valid exactly when `res_code` lies in the inclusive range 68..116 (17 kΩ to 29 kΩ). A valid signature raises `det_valid`; an invalid one leaves it at 0.
- R3: Classification lasts CLS_MS ticks (default 13). The current code maps as follows: below 13 gives class 0; 13..28 gives 1; 29..45 gives 2; 46..65 gives 3; 66..95 gives 4; 96 or more is overcurrent. The class appears on `port_class` when classification ends.
- R4: In automatic mode with a valid signature and a valid class, `gate_en` rises on the tick numbered DET_MS+CLS_MS+PON_MS (default 233) after detection starts, and not one tick earlier.
- R5: In automatic mode, a failed detection keeps the gate off and waits BACKOFF_MS ticks (default 50) before detection restarts.
- R6: In manual mode, nothing starts without `cmd_detect`. Classification waits for `cmd_classify`. The gate rises only on `cmd_power`.
- R7: In semi-automatic mode, detection and classification run without commands. The gate stays off until `cmd_power`.
- R8: `shdn` turns the gate off and clears `det_valid` on the next clock edge, and holds the port idle while it is asserted.
- R9: `pwr_good` is 1 only while the gate is on and `pg_cmp` is 1.
- R10: `ev_on` pulses for one cycle when the gate turns on. `ev_off` pulses for one cycle when the gate turns off.
- R11: An overcurrent classification pulses `ev_fault`, leaves the port unpowered, and returns to idle with `det_valid` and `port_class` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| op_mode | input | 2 | 00 manual, 01 semi-automatic, 1x automatic |
| cmd_detect | input | 1 | Start detection (manual mode) |
| cmd_classify | input | 1 | Start classification (manual mode) |
| cmd_power | input | 1 | Power the port (manual and semi-automatic modes) |
| shdn | input | 1 | Force the port off and idle |
| res_code | input | RES_W | Signature resistance, 0.25 kΩ per LSB |
| cur_code | input | CUR_W | Classification current, 0.5 mA per LSB |
| pg_cmp | input | 1 | Output-near-negative-rail comparator |
| gate_en | output | 1 | External FET gate enable |
| port_class | output | 3 | Detected class 0..4 |
| det_valid | output | 1 | Valid signature held |
| pwr_good | output | 1 | Port powered and output good |
| ev_on | output | 1 | Gate-on event pulse |
| ev_off | output | 1 | Gate-off event pulse |
| ev_fault | output | 1 | Classification overcurrent pulse |

## Verification
The assertions check several rules on every cycle:
- Shutdown always clears the gate on the next edge.
- The on and off pulses coincide with the gate's edges, and at most one event fires at a time.
- In the non-automatic modes the gate never rises without `cmd_power`.
- A fault pulse never coincides with power or a non-zero class.

Only the bench scenarios can show the remaining behaviour:
- The exact tick counts of each phase.
- The inclusive edges of the resistance window and the current thresholds.
- The backoff-and-retry length after a failed detection.
- The gating of power-good.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_BACKOFF  = 3'd1,
        ST_DETECT   = 3'd2,
        ST_DET_HOLD = 3'd3,
        ST_CLASS    = 3'd4,
        ST_WAIT_ON  = 3'd5,
        ST_POWERED  = 3'd6
    } seq_state_t;

    localparam int unsigned NUM_CLASS_TH = 5;
    localparam int unsigned CLASS_W      = 3;

endpackage

// File: rtl/pse_sig_judge.sv
module pse_sig_judge #(
    parameter int unsigned RES_W  = 8,
    parameter int unsigned RES_LO = 68,
    parameter int unsigned RES_HI = 116
) (
    input  logic [RES_W-1:0] res_code,
    output logic             sig_ok
);
    localparam logic [RES_W-1:0] LO_C = RES_W'(RES_LO);
    localparam logic [RES_W-1:0] HI_C = RES_W'(RES_HI);

    // Inclusive signature window
    assign sig_ok = (res_code >= LO_C) && (res_code <= HI_C);
endmodule

// File: rtl/pse_class_map.sv
module pse_class_map
    import pse_seq_pkg::*;
#(
    parameter int unsigned CUR_W = 8,
    parameter int unsigned CLS_TH [NUM_CLASS_TH] = '{13, 29, 46, 66, 96}
) (
    input  logic [CUR_W-1:0]   cur_code,
    output logic [CLASS_W-1:0] cls_val,
    output logic               cls_over
);
    logic [NUM_CLASS_TH-1:0] above;

    // One comparator per rising threshold
    for (genvar gi = 0; gi < NUM_CLASS_TH; gi++) begin : g_cmp
        assign above[gi] = (cur_code >= CUR_W'(CLS_TH[gi]));
    end

    always_comb begin
        cls_val = '0;
        for (int i = 0; i < NUM_CLASS_TH - 1; i++) begin
            if (above[i]) cls_val = CLASS_W'(i + 1);
        end
    end

    assign cls_over = above[NUM_CLASS_TH-1];
endmodule

// File: rtl/pse_ms_timer.sv
module pse_ms_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Fires on the tick that consumes the last count
    assign expire = tick && (cnt == CNT_W'(1));
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
    import pse_seq_pkg::*;
#(
    parameter int unsigned RES_W      = 8,
    parameter int unsigned CUR_W      = 8,
    parameter int unsigned RES_LO     = 68,
    parameter int unsigned RES_HI     = 116,
    parameter int unsigned CLS_TH [NUM_CLASS_TH] = '{13, 29, 46, 66, 96},
    parameter int unsigned DET_MS     = 200,
    parameter int unsigned CLS_MS     = 13,
    parameter int unsigned PON_MS     = 20,
    parameter int unsigned BACKOFF_MS = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic [1:0]         op_mode,
    input  logic               cmd_detect,
    input  logic               cmd_classify,
    input  logic               cmd_power,
    input  logic               shdn,
    input  logic [RES_W-1:0]   res_code,
    input  logic [CUR_W-1:0]   cur_code,
    input  logic               pg_cmp,
    output logic               gate_en,
    output logic [CLASS_W-1:0] port_class,
    output logic               det_valid,
    output logic               pwr_good,
    output logic               ev_on,
    output logic               ev_off,
    output logic               ev_fault
);
    localparam int unsigned MAX_A  = (DET_MS > CLS_MS) ? DET_MS : CLS_MS;
    localparam int unsigned MAX_B  = (PON_MS > BACKOFF_MS) ? PON_MS : BACKOFF_MS;
    localparam int unsigned MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);

    seq_state_t st, nxt;

    logic               sig_ok;
    logic [CLASS_W-1:0] cls_val;
    logic               cls_over;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_exp;
    logic               manual_m;
    logic               auto_m;

    assign manual_m = (op_mode == 2'b00);
    assign auto_m   = op_mode[1];

    pse_sig_judge #(
        .RES_W (RES_W),
        .RES_LO(RES_LO),
        .RES_HI(RES_HI)
    ) u_judge (
        .res_code(res_code),
        .sig_ok  (sig_ok)
    );

    pse_class_map #(
        .CUR_W (CUR_W),
        .CLS_TH(CLS_TH)
    ) u_cmap (
        .cur_code(cur_code),
        .cls_val (cls_val),
        .cls_over(cls_over)
    );

    pse_ms_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (ms_tick),
        .expire  (tmr_exp)
    );

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (!manual_m || cmd_detect) nxt = ST_DETECT;
            ST_BACKOFF:  if (tmr_exp) nxt = ST_IDLE;
            ST_DETECT: begin
                if (tmr_exp) begin
                    if (sig_ok) nxt = manual_m ? ST_DET_HOLD : ST_CLASS;
                    else        nxt = manual_m ? ST_IDLE : ST_BACKOFF;
                end
            end
            ST_DET_HOLD: if (cmd_classify) nxt = ST_CLASS;
            ST_CLASS: begin
                if (tmr_exp) begin
                    if (cls_over) nxt = manual_m ? ST_IDLE : ST_BACKOFF;
                    else          nxt = ST_WAIT_ON;
                end
            end
            ST_WAIT_ON:  if (auto_m ? tmr_exp : cmd_power) nxt = ST_POWERED;
            ST_POWERED:  nxt = ST_POWERED;
            default:     nxt = ST_IDLE;
        endcase
        if (shdn) nxt = ST_IDLE;
    end

    // Timer reload on every state entry
    always_comb begin
        tmr_load = (nxt != st);
        unique case (nxt)
            ST_DETECT:  tmr_val = CNT_W'(DET_MS);
            ST_CLASS:   tmr_val = CNT_W'(CLS_MS);
            ST_WAIT_ON: tmr_val = CNT_W'(PON_MS);
            ST_BACKOFF: tmr_val = CNT_W'(BACKOFF_MS);
            default:    tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en    <= 1'b0;
            det_valid  <= 1'b0;
            port_class <= '0;
            ev_on      <= 1'b0;
            ev_off     <= 1'b0;
            ev_fault   <= 1'b0;
        end else begin
            gate_en   <= (nxt == ST_POWERED);
            det_valid <= (nxt == ST_DET_HOLD) || (nxt == ST_CLASS) ||
                         (nxt == ST_WAIT_ON)  || (nxt == ST_POWERED);
            ev_on     <= (nxt == ST_POWERED) && (st != ST_POWERED);
            ev_off    <= (st == ST_POWERED) && (nxt != ST_POWERED);
            ev_fault  <= (st == ST_CLASS) && tmr_exp && cls_over && !shdn;
            if ((nxt == ST_IDLE) || (nxt == ST_BACKOFF)) begin
                port_class <= '0;
            end else if ((st == ST_CLASS) && (nxt == ST_WAIT_ON)) begin
                port_class <= cls_val;
            end
        end
    end

    assign pwr_good = gate_en && pg_cmp;
endmodule

// File: rtl/pse_port_seq_chk.sv
module pse_port_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_mode,
    input logic       cmd_power,
    input logic       shdn,
    input logic       gate_en,
    input logic       det_valid,
    input logic [2:0] port_class,
    input logic       ev_on,
    input logic       ev_off,
    input logic       ev_fault
);
    AST_SHDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (!gate_en && !det_valid)); // R8

    AST_ON_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_on |-> (gate_en && !$past(gate_en))); // R10

    AST_OFF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_en) |-> ev_off); // R10

    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_on, ev_off, ev_fault})); // R10

    AST_NEEDS_POWER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_mode[1] && !gate_en && !cmd_power) |=> !gate_en); // R6

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        port_class <= 3'd4); // R3

    AST_FAULT_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fault |-> (!gate_en && (port_class == 3'd0) && !det_valid)); // R11
endmodule

bind pse_port_seq pse_port_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_mode   (op_mode),
    .cmd_power (cmd_power),
    .shdn      (shdn),
    .gate_en   (gate_en),
    .det_valid (det_valid),
    .port_class(port_class),
    .ev_on     (ev_on),
    .ev_off    (ev_off),
    .ev_fault  (ev_fault)
);

// File: tb/pse_port_seq_bench.sv
`timescale 1ns/1ps
module pse_port_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] op_mode = 2'b10;
    logic       cmd_detect = 1'b0;
    logic       cmd_classify = 1'b0;
    logic       cmd_power = 1'b0;
    logic       shdn = 1'b0;
    logic [7:0] res_code = 8'd80;
    logic [7:0] cur_code = 8'd30;
    logic       pg_cmp = 1'b0;
    logic       gate_en, det_valid, pwr_good, ev_on, ev_off, ev_fault;
    logic [2:0] port_class;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;   // 1 on, 2 off, 3 fault
        int    cls;
        string req;
    } exp_ev_t;
    exp_ev_t exp_q[$];

    always #2.5 clk = ~clk;

    pse_port_seq u_pse_port_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .op_mode(op_mode),
        .cmd_detect(cmd_detect), .cmd_classify(cmd_classify), .cmd_power(cmd_power),
        .shdn(shdn), .res_code(res_code), .cur_code(cur_code), .pg_cmp(pg_cmp),
        .gate_en(gate_en), .port_class(port_class), .det_valid(det_valid),
        .pwr_good(pwr_good), .ev_on(ev_on), .ev_off(ev_off), .ev_fault(ev_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input int cls, input string req);
        exp_ev_t e;
        e.kind = kind; e.cls = cls; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_det();
        @(negedge clk) cmd_detect = 1'b1;
        @(negedge clk) cmd_detect = 1'b0;
    endtask

    task automatic pulse_cls();
        @(negedge clk) cmd_classify = 1'b1;
        @(negedge clk) cmd_classify = 1'b0;
    endtask

    task automatic pulse_on();
        @(negedge clk) cmd_power = 1'b1;
        @(negedge clk) cmd_power = 1'b0;
    endtask

    task automatic pulse_shdn();
        @(negedge clk) shdn = 1'b1;
        @(negedge clk) shdn = 1'b0;
    endtask

    // Monitor: pops expected events as the design raises them
    always @(negedge clk) begin
        if (rst_n && (ev_on || ev_off || ev_fault)) begin
            int k;
            k = ev_on ? 1 : (ev_off ? 2 : 3);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected event kind", k, 0);
            end else begin
                exp_ev_t e;
                e = exp_q.pop_front();
                chk(k == e.kind, e.req, "event kind", k, e.kind);
                if (k == 1) chk(int'(port_class) == e.cls, e.req, "class at power-on",
                                int'(port_class), e.cls);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int cls_codes [10] = '{12, 13, 28, 29, 45, 46, 65, 66, 95, 96};
    int cls_exp   [10] = '{0, 1, 1, 2, 2, 3, 3, 4, 4, 5};
    int res_codes [4]  = '{67, 68, 116, 117};
    int res_ok    [4]  = '{0, 1, 1, 0};

    initial begin
        // R1: reset state
        cycles(3);
        chk(!gate_en && !det_valid && !pwr_good, "R1", "outputs in reset",
            {gate_en, det_valid, pwr_good}, 0);
        chk(port_class == 0 && !ev_on && !ev_off && !ev_fault, "R1", "class/events in reset",
            {port_class, ev_on, ev_off, ev_fault}, 0);
        rst_n = 1'b1;
        cycles(2);
        chk(!gate_en && !ev_on, "R1", "just after reset", gate_en, 0);

        // R4: automatic flow, exact tick count
        tick_n(232);
        chk(gate_en == 1'b0, "R4", "gate one tick early", gate_en, 0);
        expect_ev(1, 2, "R10");
        tick_n(1);
        chk(gate_en == 1'b1, "R4", "gate at full count", gate_en, 1);
        chk(port_class == 3'd2, "R3", "class for code 30", port_class, 2);
        chk(det_valid == 1'b1, "R2", "det_valid after good signature", det_valid, 1);
        chk(pwr_good == 1'b0, "R9", "pwr_good with comparator low", pwr_good, 0);
        @(negedge clk) pg_cmp = 1'b1;
        cycles(1);
        chk(pwr_good == 1'b1, "R9", "pwr_good with comparator high", pwr_good, 1);

        // R8: shutdown while powered, then held
        expect_ev(2, 0, "R10");
        @(negedge clk) shdn = 1'b1;
        cycles(2);
        chk(!gate_en && !det_valid, "R8", "gate/valid after shutdown", {gate_en, det_valid}, 0);
        chk(pwr_good == 1'b0, "R9", "pwr_good after shutdown", pwr_good, 0);
        tick_n(300);
        chk(!gate_en && !det_valid, "R8", "held idle under shutdown", {gate_en, det_valid}, 0);

        // R5: failed detection, backoff, retry
        res_code = 8'd64;
        @(negedge clk) shdn = 1'b0;
        cycles(2);
        tick_n(200);
        chk(!det_valid && !gate_en, "R5", "failed signature", {det_valid, gate_en}, 0);
        res_code = 8'd80;
        tick_n(282);
        chk(gate_en == 1'b0, "R5", "gate before backoff+retry", gate_en, 0);
        expect_ev(1, 2, "R10");
        tick_n(1);
        chk(gate_en == 1'b1, "R5", "gate after backoff+retry", gate_en, 1);

        // R6: manual mode stays idle without commands
        expect_ev(2, 0, "R10");
        @(negedge clk) begin shdn = 1'b1; op_mode = 2'b00; end
        cycles(2);
        @(negedge clk) shdn = 1'b0;
        tick_n(250);
        chk(!det_valid && !gate_en, "R6", "manual idle without command", {det_valid, gate_en}, 0);

        // R2: signature window edges
        for (int i = 0; i < 4; i++) begin
            res_code = 8'(res_codes[i]);
            pulse_det();
            tick_n(200);
            chk(int'(det_valid) == res_ok[i], "R2", $sformatf("window code %0d", res_codes[i]),
                det_valid, res_ok[i]);
            pulse_shdn();
            cycles(1);
        end
        res_code = 8'd80;

        // R3 / R11: class thresholds in manual mode
        for (int i = 0; i < 10; i++) begin
            cur_code = 8'(cls_codes[i]);
            pulse_det();
            tick_n(200);
            pulse_cls();
            if (cls_exp[i] == 5) expect_ev(3, 0, "R11");
            tick_n(13);
            if (cls_exp[i] == 5) begin
                chk(!gate_en && !det_valid && port_class == 0, "R11", "overcurrent outcome",
                    {gate_en, det_valid, port_class}, 0);
            end else begin
                chk(int'(port_class) == cls_exp[i], "R3",
                    $sformatf("class for code %0d", cls_codes[i]), port_class, cls_exp[i]);
                if (i == 0) begin
                    tick_n(30);
                    chk(gate_en == 1'b0, "R6", "manual waits for power cmd", gate_en, 0);
                end
                if (i == 8) begin
                    expect_ev(1, 4, "R6");
                    pulse_on();
                    cycles(1);
                    chk(gate_en == 1'b1, "R6", "manual power cmd", gate_en, 1);
                    expect_ev(2, 0, "R10");
                end
                pulse_shdn();
                cycles(1);
            end
        end

        // R7: semi-automatic
        cur_code = 8'd50;
        @(negedge clk) op_mode = 2'b01;
        cycles(2);
        tick_n(213);
        chk(det_valid == 1'b1 && gate_en == 1'b0, "R7", "semi ran detect and class",
            {det_valid, gate_en}, 2);
        chk(port_class == 3'd3, "R7", "semi class", port_class, 3);
        tick_n(100);
        chk(gate_en == 1'b0, "R7", "semi waits for power cmd", gate_en, 0);
        expect_ev(1, 3, "R7");
        pulse_on();
        cycles(1);
        chk(gate_en == 1'b1, "R7", "semi power cmd", gate_en, 1);
        expect_ev(2, 0, "R10");
        @(negedge clk) shdn = 1'b1;
        cycles(4);

        chk(exp_q.size() == 0, "R10", "pending expected events", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule